// File: doc/BRIEF.md
# Bridge Address Forwarding Decoder

This block decides, for each transaction address seen at a two-sided bridge, whether the bridge claims the access and passes it to the other side. The caller presents an address, whether the access is memory or I/O, and whether it travels downstream (primary to secondary) or upstream (secondary to primary). One clock later the block gives a registered forward-or-ignore answer.

The answer combines three rules. The first is a 16-bit I/O window, set by a base and a limit at 4 KB granularity. The second is a legacy display decode that claims the 0xA0000–0xBFFFF memory hole and the display I/O ports at every 1 KB alias. The third is a legacy ISA rule that splits each 1 KB block of the low 64 KB of I/O space.

The block also holds the bridge's interrupt and control register with its write rules. It gates a secondary-side system error indication onto the primary side.

Top module: `bridge_fwd_decoder`

## Requirements
- R1: After reset, both configuration registers read 0, fwd_o is 0 and serr_o is 0.
- R2: fwd_o takes the decision for the transaction presented with txn_valid_i high at a rising clock edge. It holds that value on every edge where txn_valid_i is low.
- R3: A downstream memory access is forwarded only when the display enable bit is set and the address lies in 0xA0000 to 0xBFFFF inclusive.
- R4: With display enable set, a downstream I/O access is forwarded whenever address bits [31:16] are 0 and bits [9:0] lie in 0x3B0–0x3BB or 0x3C0–0x3DF. Bits [15:10] are not examined, and this holds regardless of window and ISA setting.
- R5: A downstream I/O access is forwarded when bits [31:16] are 0 and base <= addr[15:12] <= limit. A limit below the base forwards no I/O through the window.
- R6: With the ISA enable bit set, a downstream I/O access inside the window is blocked when addr[9:8] is not 00, unless R4 claims it.
- R7: An upstream I/O access is forwarded when it lies outside the window, or inside it with ISA enable set and addr[9:8] not 00. It is never forwarded when R4's display alias match applies with display enable set.
- R8: An upstream memory access is forwarded unless display enable is set and the address lies in 0xA0000–0xBFFFF.
- R9: serr_o is high only while sec_serr_i, cmd_serr_en_i and the control register's error enable bit are all high.
- R10: The control register is selected by cfg_sel_i=0. Its layout is: display enable at bit 19, ISA enable at bit 18, error enable at bit 17, interrupt pin at bits 15:8 and interrupt line at bits 7:0. Bit 16 (parity response) always reads 0 and ignores writes.
- R11: Interrupt pin bits take a write only while int_pin_wen_i is 1; otherwise they keep their value. Interrupt line bits always take the write.
- R12: The window register is selected by cfg_sel_i=1. It holds the base at bits 3:0 and the limit at bits 7:4; bits 19:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Register select: 0 control, 1 window |
| cfg_wdata_i | input | 20 | Configuration write data |
| int_pin_wen_i | input | 1 | Allows writes to the interrupt pin field |
| cfg_rdata_o | output | 20 | Read-back of the selected register |
| txn_valid_i | input | 1 | Address strobe |
| txn_addr_i | input | 32 | Transaction address |
| txn_is_io_i | input | 1 | 1 = I/O, 0 = memory |
| txn_up_i | input | 1 | 1 = upstream, 0 = downstream |
| fwd_o | output | 1 | Registered forward decision |
| sec_serr_i | input | 1 | Secondary-side system error |
| cmd_serr_en_i | input | 1 | Primary command-register error enable |
| serr_o | output | 1 | Gated system error toward primary |

## Verification
The hardest cases to reach arise where the window, the ISA split and the display aliases overlap. One such case is an upstream I/O access at a high alias such as 0x73C5, with the window covering it and both enables set. There the ISA rule says forward and the display rule says keep. The stimulus reaches these cases by crossing every enable combination, several windows (including an inverted one), both directions and a dense low-10-bit sweep at several 4 KB pages and above 64 KB. Added to this is a list of range-edge offsets replayed at an aliased page.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  localparam int CFG_W        = 20;
  localparam int LINE_LSB     = 0;
  localparam int PIN_LSB      = 8;
  localparam int PAR_BIT      = 16;
  localparam int SERR_BIT     = 17;
  localparam int ISA_BIT      = 18;
  localparam int VGA_BIT      = 19;

  typedef struct packed {
    logic       vga_en;
    logic       isa_en;
    logic       serr_en;
    logic [7:0] int_pin;
    logic [7:0] int_line;
  } ctrl_t;
endpackage

// File: rtl/bfd_cfg_regs.sv
module bfd_cfg_regs
  import bfd_pkg::*;
#(
  parameter int WIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             pin_wen_i,
  output logic [CFG_W-1:0] rdata_o,
  output ctrl_t            ctrl_o,
  output logic [WIN_W-1:0] base_o,
  output logic [WIN_W-1:0] limit_o
);
  ctrl_t            ctrl_q;
  logic [WIN_W-1:0] base_q, limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else if (we_i) begin
      if (!sel_i) begin
        ctrl_q.vga_en   <= wdata_i[VGA_BIT];
        ctrl_q.isa_en   <= wdata_i[ISA_BIT];
        ctrl_q.serr_en  <= wdata_i[SERR_BIT];
        ctrl_q.int_line <= wdata_i[LINE_LSB +: 8];
        if (pin_wen_i) ctrl_q.int_pin <= wdata_i[PIN_LSB +: 8];
      end else begin
        base_q  <= wdata_i[0 +: WIN_W];
        limit_q <= wdata_i[WIN_W +: WIN_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!sel_i) begin
      rdata_o[VGA_BIT]        = ctrl_q.vga_en;
      rdata_o[ISA_BIT]        = ctrl_q.isa_en;
      rdata_o[SERR_BIT]       = ctrl_q.serr_en;
      rdata_o[PAR_BIT]        = 1'b0;
      rdata_o[PIN_LSB +: 8]   = ctrl_q.int_pin;
      rdata_o[LINE_LSB +: 8]  = ctrl_q.int_line;
    end else begin
      rdata_o[0 +: WIN_W]     = base_q;
      rdata_o[WIN_W +: WIN_W] = limit_q;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign base_o  = base_q;
  assign limit_o = limit_q;
endmodule

// File: rtl/bfd_io_decode.sv
module bfd_io_decode #(
  parameter int ADDR_W  = 32,
  parameter int WIN_W   = 4,
  parameter int WIN_LSB = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIN_W-1:0]  base_i,
  input  logic [WIN_W-1:0]  limit_i,
  input  logic              isa_en_i,
  output logic              in_win_o,
  output logic              isa_top_o
);
  localparam int LOW_W = WIN_LSB + WIN_W;

  logic             low_space;
  logic [WIN_W-1:0] page;

  assign low_space = ~|addr_i[ADDR_W-1:LOW_W];
  assign page      = addr_i[LOW_W-1:WIN_LSB];
  // limit < base leaves the window empty
  assign in_win_o  = low_space && (limit_i >= base_i) && (page >= base_i) && (page <= limit_i);
  // top 768 bytes of each 1 KB block
  assign isa_top_o = isa_en_i && |addr_i[9:8];
endmodule

// File: rtl/bfd_vga_decode.sv
module bfd_vga_decode #(
  parameter int ADDR_W   = 32,
  parameter int IO_LOW_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vga_en_i,
  output logic              mem_hit_o,
  output logic              io_hit_o
);
  localparam logic [ADDR_W-1:0] MEM_LO = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] MEM_HI = ADDR_W'(32'h000B_FFFF);

  logic [9:0] a10;
  logic       low_space;
  logic       mono_hit, color_hit;

  assign a10       = addr_i[9:0];
  assign low_space = ~|addr_i[ADDR_W-1:IO_LOW_W];
  assign mono_hit  = (a10 >= 10'h3B0) && (a10 <= 10'h3BB);
  assign color_hit = (a10 >= 10'h3C0) && (a10 <= 10'h3DF);

  assign mem_hit_o = vga_en_i && (addr_i >= MEM_LO) && (addr_i <= MEM_HI);
  assign io_hit_o  = vga_en_i && low_space && (mono_hit || color_hit);
endmodule

// File: rtl/bridge_fwd_decoder.sv
module bridge_fwd_decoder
  import bfd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WIN_W   = 4,
  parameter int WIN_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              int_pin_wen_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              txn_valid_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic              txn_is_io_i,
  input  logic              txn_up_i,
  output logic              fwd_o,
  input  logic              sec_serr_i,
  input  logic              cmd_serr_en_i,
  output logic              serr_o
);
  ctrl_t            ctrl;
  logic [WIN_W-1:0] io_base, io_limit;
  logic             in_win, isa_top, vga_mem, vga_io;
  logic             fwd_d, fwd_q;

  bfd_cfg_regs #(.WIN_W(WIN_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .pin_wen_i (int_pin_wen_i),
    .rdata_o   (cfg_rdata_o),
    .ctrl_o    (ctrl),
    .base_o    (io_base),
    .limit_o   (io_limit)
  );

  bfd_io_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .WIN_LSB(WIN_LSB)) u_io (
    .addr_i    (txn_addr_i),
    .base_i    (io_base),
    .limit_i   (io_limit),
    .isa_en_i  (ctrl.isa_en),
    .in_win_o  (in_win),
    .isa_top_o (isa_top)
  );

  bfd_vga_decode #(.ADDR_W(ADDR_W), .IO_LOW_W(WIN_LSB + WIN_W)) u_vga (
    .addr_i    (txn_addr_i),
    .vga_en_i  (ctrl.vga_en),
    .mem_hit_o (vga_mem),
    .io_hit_o  (vga_io)
  );

  always_comb begin
    if (txn_is_io_i) begin
      if (txn_up_i) fwd_d = (!in_win || isa_top) && !vga_io;
      else          fwd_d = (in_win && !isa_top) || vga_io;
    end else begin
      fwd_d = txn_up_i ? !vga_mem : vga_mem;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fwd_q <= 1'b0;
    else if (txn_valid_i) fwd_q <= fwd_d;
  end

  assign fwd_o  = fwd_q;
  assign serr_o = sec_serr_i && cmd_serr_en_i && ctrl.serr_en;
endmodule

// File: rtl/bfd_checker.sv
module bfd_checker
  import bfd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              txn_valid_i,
  input logic [ADDR_W-1:0] txn_addr_i,
  input logic              txn_is_io_i,
  input logic              txn_up_i,
  input logic              cfg_we_i,
  input logic              cfg_sel_i,
  input logic              int_pin_wen_i,
  input logic [CFG_W-1:0]  cfg_rdata_o,
  input logic              sec_serr_i,
  input logic              cmd_serr_en_i,
  input logic              serr_o,
  input logic              fwd_o,
  input ctrl_t             ctrl
);
  AST_FWD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txn_valid_i |=> $stable(fwd_o)); // R2
  AST_MEM_DOWN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && !txn_is_io_i && !txn_up_i && !ctrl.vga_en) |=> !fwd_o); // R3
  AST_ISA_DOWN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && txn_is_io_i && !txn_up_i && ctrl.isa_en && !ctrl.vga_en
     && (txn_addr_i[9:8] != 2'b00)) |=> !fwd_o); // R6
  AST_UP_MEM_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_valid_i && !txn_is_io_i && txn_up_i && !ctrl.vga_en) |=> fwd_o); // R8
  AST_SERR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> (sec_serr_i && cmd_serr_en_i)); // R9
  AST_PAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_sel_i |-> !cfg_rdata_o[PAR_BIT]); // R10
  AST_PIN_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_sel_i && !int_pin_wen_i) |=> $stable(ctrl.int_pin)); // R11
endmodule

bind bridge_fwd_decoder bfd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .txn_valid_i   (txn_valid_i),
  .txn_addr_i    (txn_addr_i),
  .txn_is_io_i   (txn_is_io_i),
  .txn_up_i      (txn_up_i),
  .cfg_we_i      (cfg_we_i),
  .cfg_sel_i     (cfg_sel_i),
  .int_pin_wen_i (int_pin_wen_i),
  .cfg_rdata_o   (cfg_rdata_o),
  .sec_serr_i    (sec_serr_i),
  .cmd_serr_en_i (cmd_serr_en_i),
  .serr_o        (serr_o),
  .fwd_o         (fwd_o),
  .ctrl          (ctrl)
);

// File: tb/tb_bridge_fwd_decoder.sv
`timescale 1ns/1ps
module tb_bridge_fwd_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0, int_pin_wen_i = 1'b0;
  logic [19:0] cfg_wdata_i = '0;
  logic [19:0] cfg_rdata_o;
  logic        txn_valid_i = 1'b0, txn_is_io_i = 1'b0, txn_up_i = 1'b0;
  logic [31:0] txn_addr_i = '0;
  logic        fwd_o, serr_o;
  logic        sec_serr_i = 1'b0, cmd_serr_en_i = 1'b0;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  bridge_fwd_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .int_pin_wen_i(int_pin_wen_i), .cfg_rdata_o(cfg_rdata_o),
    .txn_valid_i(txn_valid_i), .txn_addr_i(txn_addr_i), .txn_is_io_i(txn_is_io_i),
    .txn_up_i(txn_up_i), .fwd_o(fwd_o), .sec_serr_i(sec_serr_i),
    .cmd_serr_en_i(cmd_serr_en_i), .serr_o(serr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [19:0] d, input logic pw);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d; int_pin_wen_i = pw;
    @(posedge clk);
    @(negedge clk);
    cfg_we_i = 1'b0; int_pin_wen_i = 1'b0;
  endtask

  task automatic cfg_read(input logic sel, output logic [19:0] d);
    @(negedge clk);
    cfg_sel_i = sel;
    #1 d = cfg_rdata_o;
  endtask

  function automatic logic model(input logic [31:0] a, input logic io, input logic up,
                                 input logic vga, input logic isa, input int base, input int lim);
    logic low, in_win, top, vio, vmem;
    int   pg, l10;
    low    = a < 32'h10000;
    pg     = int'((a >> 12) & 32'hF);
    l10    = int'(a % 1024);
    in_win = low && (lim >= base) && (pg >= base) && (pg <= lim);
    top    = isa && (l10 >= 256);
    vio    = vga && low && (((l10 >= 'h3B0) && (l10 <= 'h3BB)) || ((l10 >= 'h3C0) && (l10 <= 'h3DF)));
    vmem   = vga && (a >= 32'hA0000) && (a <= 32'hBFFFF);
    if (io) return up ? ((!in_win || top) && !vio) : ((in_win && !top) || vio);
    return up ? !vmem : vmem;
  endfunction

  function automatic string req_of(input logic io, input logic up, input logic vga, input logic isa,
                                   input logic [31:0] a);
    if (!io) return up ? "R8" : "R3";
    if (up) return "R7";
    if (vga && (a[9:0] >= 10'h3B0) && (a[9:0] <= 10'h3DF)) return "R4";
    return isa ? "R6" : "R5";
  endfunction

  task automatic txn(input logic [31:0] a, input logic io, input logic up,
                     input logic vga, input logic isa, input int base, input int lim);
    @(negedge clk);
    txn_valid_i = 1'b1; txn_addr_i = a; txn_is_io_i = io; txn_up_i = up;
    @(posedge clk);
    @(negedge clk);
    txn_valid_i = 1'b0;
    check(req_of(io, up, vga, isa, a), {31'd0, fwd_o}, {31'd0, model(a, io, up, vga, isa, base, lim)});
  endtask

  initial begin : watchdog
    #(8ns * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [19:0] rd;
    int bases[3] = '{0, 2, 6};
    int lims[3]  = '{15, 5, 3};
    int highs[6] = '{'h0000, 'h1000, 'h3000, 'h5000, 'hF000, 'h10000};
    int edges[10] = '{'h3AF, 'h3B0, 'h3BB, 'h3BC, 'h3BF, 'h3C0, 'h3DF, 'h3E0, 'h0FF, 'h100};
    int mems[6]  = '{'h0, 'h9FFFF, 'hA0000, 'hB1234, 'hBFFFF, 'hC0000};

    repeat (3) @(negedge clk);
    // R1 reset state
    cfg_read(1'b0, rd); check("R1", {12'd0, rd}, 32'h0);
    cfg_read(1'b1, rd); check("R1", {12'd0, rd}, 32'h0);
    check("R1", {31'd0, fwd_o}, 32'h0);
    check("R1", {31'd0, serr_o}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    // R10, R11 control register rules
    cfg_write(1'b0, 20'hFFFFF, 1'b0);
    cfg_read(1'b0, rd); check("R11", {12'd0, rd}, 32'h000E00FF);
    cfg_write(1'b0, 20'hF5A3C, 1'b1);
    cfg_read(1'b0, rd); check("R11", {12'd0, rd}, 32'h000E5A3C);
    check("R10", {31'd0, rd[16]}, 32'h0);
    cfg_write(1'b0, 20'h1FF11, 1'b0);
    cfg_read(1'b0, rd); check("R10", {12'd0, rd}, 32'h00005A11);
    // R12 window register layout
    cfg_write(1'b1, 20'hFFFFF, 1'b0);
    cfg_read(1'b1, rd); check("R12", {12'd0, rd}, 32'h000000FF);
    cfg_read(1'b0, rd); check("R12", {12'd0, rd}, 32'h00005A11);

    // R9 error gating, all 8 combinations
    for (int m = 0; m < 8; m++) begin
      cfg_write(1'b0, {2'b00, m[0], 17'h0}, 1'b0);
      @(negedge clk);
      sec_serr_i = m[1]; cmd_serr_en_i = m[2];
      #1 check("R9", {31'd0, serr_o}, {31'd0, m[0] & m[1] & m[2]});
    end
    sec_serr_i = 1'b0; cmd_serr_en_i = 1'b0;

    // I/O and memory sweeps over windows and enable modes
    for (int w = 0; w < 3; w++) begin
      cfg_write(1'b1, 20'(lims[w] * 16 + bases[w]), 1'b0);
      for (int md = 0; md < 4; md++) begin
        cfg_write(1'b0, {md[1], md[0], 18'h0}, 1'b0);
        for (int up = 0; up < 2; up++) begin
          for (int h = 0; h < 6; h++)
            for (int j = 0; j < 256; j++)
              txn(32'(highs[h] + j * 4 + (j & 3)), 1'b1, up[0], md[1], md[0], bases[w], lims[w]);
          for (int e = 0; e < 10; e++)
            txn(32'('h7000 + edges[e]), 1'b1, up[0], md[1], md[0], bases[w], lims[w]);
          for (int e = 0; e < 6; e++)
            txn(32'(mems[e]), 1'b0, up[0], md[1], md[0], bases[w], lims[w]);
        end
      end
    end

    // R2 hold while strobe is low
    cfg_write(1'b1, 20'hF0, 1'b0);
    cfg_write(1'b0, 20'h0, 1'b0);
    txn(32'h100, 1'b1, 1'b0, 1'b0, 1'b0, 0, 15);
    check("R2", {31'd0, fwd_o}, 32'h1);
    @(negedge clk);
    txn_addr_i = 32'h20000; txn_is_io_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", {31'd0, fwd_o}, 32'h1);
    txn(32'h20000, 1'b0, 1'b0, 1'b0, 1'b0, 0, 15);
    check("R2", {31'd0, fwd_o}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule